// File: doc/BRIEF.md
# DRAM Row-Buffer Policy Controller

This block models the scheduling of one DRAM bank that has a single row buffer. Each incoming request carries a row address, an arrival timestamp in 1 ns ticks and a row-management policy code. The block sorts every access into one of three cases. A hit means the wanted row is already open. An empty access means the bank is precharged and no row is open. A conflict means a different row is open. From that case it computes when the access completes, and it remembers when the bank becomes free again.

Requests are served strictly in the order they are presented, one per clock. An access starts at the later of its own arrival time and the completion time of the previous access. The policy given with a request decides what happens to its row once the access is done. The open policy leaves the row open. The closed policy precharges it. The adaptive policy keeps the row open only if the following request is already waiting and wants the same row.

The adaptive decision cannot be made until the following request is seen. The block therefore resolves it when that request arrives, using the stored policy, row and finish time of the previous request. The result for each request is registered and appears one clock after the request is accepted.

Top module: `rowbuf_ctrl`

## Requirements
- R1: After synchronous reset no row is open, the bank is free at time 0, `done_valid` is low, and the first request is classified as empty.
- R2: A request accepted at a clock edge produces exactly one result, with `done_valid` high for the one clock that follows that edge. `done_valid` stays low after any edge with no request.
- R3: An access starts at the later of its arrival time and the previous request's completion time. The reported completion time is the start plus the latency of its case.
- R4: The latency of a hit is HIT_LAT (20), of an empty access EMPTY_LAT (40), and of a conflict CONF_LAT (60) ticks.
- R5: `done_case` reports 0 for a hit, 1 for empty and 2 for a conflict. It never reports 3.
- R6: Policy code 0 (open) and code 3 (treated as open) leave the row open after the access. The next request is then a hit for the same row and a conflict for any other row.
- R7: Policy code 1 (closed) precharges after the access. A next request that arrives at or after the previous completion time sees an empty bank. A next request that arrives strictly earlier finds the row still open: a hit for the same row, a conflict otherwise.
- R8: Policy code 2 (adaptive) keeps the row open only when the next request arrives strictly before the previous completion time and targets the same row, which makes it a hit. In every other case the next request sees an empty bank. This policy never leads to a conflict.
- R9: The row handling after a request is governed by the policy code presented with that request, not by the code presented with the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_row | input | ROW_W | Row address of the request |
| req_arrival | input | TIME_W | Arrival time of the request in ticks |
| req_policy | input | 2 | Row policy after this access: 0 open, 1 closed, 2 adaptive, 3 open |
| done_valid | output | 1 | Result of the request accepted at the previous edge |
| done_time | output | TIME_W | Completion time of that request |
| done_case | output | 2 | 0 hit, 1 empty, 2 conflict |

## Verification
Every result is due exactly one clock after the edge that accepts its request. There is one register stage between the request inputs and the outputs. The bench drives a request just after a falling edge and removes it at the next falling edge. It then checks valid, case and completion time at that falling edge, halfway after the capturing rising edge. The bench also checks one further falling edge later that `done_valid` has dropped. Expected cases and times come from an arithmetic model of the rules above. That model is swept over every policy, every 6-request pattern of two rows, and arrival gaps that land before, exactly on and after the previous completion time.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;

  typedef enum logic [1:0] {
    CASE_HIT      = 2'd0,
    CASE_EMPTY    = 2'd1,
    CASE_CONFLICT = 2'd2
  } access_case_t;

  typedef enum logic [1:0] {
    POL_OPEN     = 2'd0,
    POL_CLOSE    = 2'd1,
    POL_ADAPT    = 2'd2,
    POL_OPEN_ALT = 2'd3
  } row_policy_t;

endpackage

// File: rtl/rowbuf_classify.sv
module rowbuf_classify
  import rowbuf_pkg::*;
#(
  parameter int ROW_W  = 14,
  parameter int TIME_W = 32
) (
  input  logic              have_row,
  input  logic [ROW_W-1:0]  last_row,
  input  row_policy_t       last_pol,
  input  logic [TIME_W-1:0] free_at,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [TIME_W-1:0] req_arrival,
  output access_case_t      kind
);

  logic same_row;
  logic queued;

  // queued: this request was waiting before the previous access finished
  assign same_row = (req_row == last_row);
  assign queued   = (req_arrival < free_at);

  always_comb begin
    kind = CASE_EMPTY;
    if (have_row) begin
      unique case (last_pol)
        POL_OPEN, POL_OPEN_ALT:
          kind = same_row ? CASE_HIT : CASE_CONFLICT;
        POL_CLOSE:
          if (queued) kind = same_row ? CASE_HIT : CASE_CONFLICT;
          else        kind = CASE_EMPTY;
        POL_ADAPT:
          kind = (queued && same_row) ? CASE_HIT : CASE_EMPTY;
        default:
          kind = CASE_EMPTY;
      endcase
    end
  end

endmodule

// File: rtl/rowbuf_timing.sv
module rowbuf_timing
  import rowbuf_pkg::*;
#(
  parameter int TIME_W    = 32,
  parameter int HIT_LAT   = 20,
  parameter int EMPTY_LAT = 40,
  parameter int CONF_LAT  = 60
) (
  input  access_case_t      kind,
  input  logic [TIME_W-1:0] req_arrival,
  input  logic [TIME_W-1:0] free_at,
  output logic [TIME_W-1:0] finish
);

  localparam logic [TIME_W-1:0] LAT_HIT   = TIME_W'(HIT_LAT);
  localparam logic [TIME_W-1:0] LAT_EMPTY = TIME_W'(EMPTY_LAT);
  localparam logic [TIME_W-1:0] LAT_CONF  = TIME_W'(CONF_LAT);

  logic [TIME_W-1:0] start;
  logic [TIME_W-1:0] lat;

  assign start = (req_arrival > free_at) ? req_arrival : free_at;

  always_comb begin
    unique case (kind)
      CASE_HIT:      lat = LAT_HIT;
      CASE_CONFLICT: lat = LAT_CONF;
      default:       lat = LAT_EMPTY;
    endcase
  end

  assign finish = start + lat;

endmodule

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl
  import rowbuf_pkg::*;
#(
  parameter int ROW_W     = 14,
  parameter int TIME_W    = 32,
  parameter int HIT_LAT   = 20,
  parameter int EMPTY_LAT = 40,
  parameter int CONF_LAT  = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [TIME_W-1:0] req_arrival,
  input  logic [1:0]        req_policy,
  output logic              done_valid,
  output logic [TIME_W-1:0] done_time,
  output logic [1:0]        done_case
);

  localparam logic [TIME_W-1:0] LAT_MIN = TIME_W'(HIT_LAT);

  // bank state left behind by the last served request
  logic              have_row;
  logic [ROW_W-1:0]  last_row;
  row_policy_t       last_pol;
  logic [TIME_W-1:0] free_at;

  access_case_t      kind;
  logic [TIME_W-1:0] finish;

  rowbuf_classify #(
    .ROW_W  (ROW_W),
    .TIME_W (TIME_W)
  ) u_classify (
    .have_row    (have_row),
    .last_row    (last_row),
    .last_pol    (last_pol),
    .free_at     (free_at),
    .req_row     (req_row),
    .req_arrival (req_arrival),
    .kind        (kind)
  );

  rowbuf_timing #(
    .TIME_W    (TIME_W),
    .HIT_LAT   (HIT_LAT),
    .EMPTY_LAT (EMPTY_LAT),
    .CONF_LAT  (CONF_LAT)
  ) u_timing (
    .kind        (kind),
    .req_arrival (req_arrival),
    .free_at     (free_at),
    .finish      (finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      have_row <= 1'b0;
      last_row <= '0;
      last_pol <= POL_OPEN;
      free_at  <= '0;
    end else if (req_valid) begin
      have_row <= 1'b1;
      last_row <= req_row;
      last_pol <= row_policy_t'(req_policy);
      free_at  <= finish;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid <= 1'b0;
      done_time  <= '0;
      done_case  <= CASE_HIT;
    end else begin
      done_valid <= req_valid;
      if (req_valid) begin
        done_time <= finish;
        done_case <= kind;
      end
    end
  end

  // R2: one result per request, none without one
  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !done_valid);

  // R3: completion never earlier than arrival or previous free time plus shortest latency
  a_r3_after_arrival: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done_time >= $past(req_arrival) + LAT_MIN);
  a_r3_after_free: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done_time >= $past(free_at) + LAT_MIN);

  // R1: a bank with no row yet can only give an empty access
  a_r1_first_empty: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !have_row) |=> done_case == CASE_EMPTY);

  // R5: code 3 never reported
  a_r5_code_range: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> done_case != 2'd3);

  // R8: the adaptive policy never causes a conflict
  a_r8_adapt_no_conflict: assert property (@(posedge clk) disable iff (rst)
    (req_valid && have_row && last_pol == POL_ADAPT) |=> done_case != CASE_CONFLICT);

endmodule

// File: tb/rowbuf_ctrl_tb.sv
`timescale 1ns/1ps
module rowbuf_ctrl_tb;

  localparam int ROW_W  = 14;
  localparam int TIME_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [TIME_W-1:0] req_arrival = '0;
  logic [1:0]        req_policy = '0;
  logic              done_valid;
  logic [TIME_W-1:0] done_time;
  logic [1:0]        done_case;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // bench model of the bank
  bit       m_have;
  int       m_row;
  int       m_pol;
  longint   m_free;

  always #5 clk = ~clk;

  rowbuf_ctrl #(.ROW_W(ROW_W), .TIME_W(TIME_W)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_row     (req_row),
    .req_arrival (req_arrival),
    .req_policy  (req_policy),
    .done_valid  (done_valid),
    .done_time   (done_time),
    .done_case   (done_case)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_have = 1'b0; m_row = 0; m_pol = 0; m_free = 0;
    @(negedge clk);
    check("R1 done_valid after reset", done_valid, 0);
  endtask

  task automatic send(input int row, input longint arr, input int pol, input bool_mix);
    int     kind;
    int     lat;
    longint start;
    bit     queued;
    bit     same;
    string  tag;
    queued = (arr < m_free);
    same   = (row == m_row);
    if (!m_have) begin
      kind = 1; tag = "R1";
    end else if (m_pol == 1) begin
      kind = queued ? (same ? 0 : 2) : 1; tag = "R7";
    end else if (m_pol == 2) begin
      kind = (queued && same) ? 0 : 1; tag = "R8";
    end else begin
      kind = same ? 0 : 2; tag = "R6";
    end
    if (bool_mix) tag = {tag, " R9"};
    lat   = (kind == 0) ? 20 : (kind == 1) ? 40 : 60;
    start = (arr > m_free) ? arr : m_free;
    req_row     = ROW_W'(row);
    req_arrival = TIME_W'(arr);
    req_policy  = 2'(pol);
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 done_valid", done_valid, 1);
    check({tag, " R5 case"}, done_case, kind);
    check("R3 R4 completion time", done_time, start + lat);
    m_have = 1'b1; m_row = row; m_pol = pol; m_free = start + lat;
  endtask

  initial begin
    int gaps [4] = '{0, 20, 40, 90};
    @(negedge clk);
    do_reset();
    check("R1 done_time after reset", done_time, 0);
    for (int p = 0; p < 5; p++) begin
      for (int pat = 0; pat < 64; pat++) begin
        longint arr;
        do_reset();
        arr = 5 + pat;
        for (int k = 0; k < 6; k++) begin
          int row;
          int pol;
          row = ((pat >> k) & 1) * 3;
          pol = (p < 4) ? p : ((pat + k) % 4);
          send(row, arr, pol, p == 4);
          arr += gaps[(pat * 5 + k * 3 + p) % 4];
        end
        @(negedge clk);
        check("R2 idle after result", done_valid, 0);
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule